// File: doc/BRIEF.md
# Host-to-Controller Doorbell Mailbox

The block sits between a host processor and an auxiliary controller core. The host sees a 32-bit register bus with byte addresses and byte enables. To issue a request, the host loads up to four payload words into an outbound buffer. It then writes a command word, which is the doorbell, and polls the status word until the busy flag drops. Once busy is low and the error bit is clear, the host reads the controller's reply from an inbound buffer. Two pointer registers are passed through to the controller unchanged.

On the controller side there is a plain signal port. The controller receives a one-cycle interrupt pulse and the latched command word. It reads the outbound buffer by word index and writes the inbound buffer by word index. It ends the transaction with a done strobe that carries an error flag and an 8-bit error code. The block tracks only the busy/done handshake. It gives no meaning to the commands it carries.

Top module: `ipc_mbox`

## Requirements
- R1: A host write to byte address 0x00 while busy is low is accepted. `ctl_cmd_o` takes the written word and status bit 0 (busy) reads 1 from the next cycle. The byte enables play no part in this.
- R2: Each accepted command produces `ctl_irq_o` high for exactly the one cycle after the accepting edge. At all other times it is low.
- R3: A command write while busy is high is ignored. It raises no interrupt and leaves `ctl_cmd_o` and the status word unchanged.
- R4: `ctl_done_i` while busy clears busy at that edge. It also copies `ctl_err_i` to status bit 1 and `ctl_err_code_i` to status bits 23:16.
- R5: `ctl_done_i` while busy is low has no effect on the status word.
- R6: The status word at 0x04 has this layout: bit 0 busy, bit 1 error, bits 7:4 the sub-ID taken from bits 15:12 of the accepted command, bits 15:8 the `host_id_i` value sampled at acceptance, bits 23:16 the error code. Bits 3:2 and 31:24 read zero.
- R7: Address 0x00 reads as zero. Writes to 0x04 are ignored. Unmapped addresses read zero.
- R8: The outbound buffer has word i at 0x80+4i. A write with all four byte enables stores the word. A write with any enable low leaves the word unchanged. The host can read the buffer back, and the controller sees word `ctl_wbuf_idx_i` on `ctl_wbuf_data_o`.
- R9: The inbound buffer has word i at 0x90+4i. The controller writes it with `ctl_rbuf_we_i`. The host reads it, and host writes to it are ignored.
- R10: The pointer words at 0x08 and 0x0C are read/write and drive `ctl_sptr_o` and `ctl_dptr_o`. Writes with partial byte enables are dropped.
- R11: Once reset is released, the status word, both pointers, the command word and all buffer words are zero, and `ctl_irq_o` is low.
- R12: An accepted command clears the error bit and the error code to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | AW | Host byte address (reads are combinational) |
| host_wdata_i | input | 32 | Host write data |
| host_be_i | input | 4 | Host byte enables |
| host_id_i | input | 8 | Initiator ID, sampled on doorbell |
| host_rdata_o | output | 32 | Host read data |
| ctl_irq_o | output | 1 | One-cycle interrupt to the controller |
| ctl_cmd_o | output | 32 | Latched command word |
| ctl_sptr_o | output | 32 | Source pointer |
| ctl_dptr_o | output | 32 | Destination pointer |
| ctl_wbuf_idx_i | input | clog2(NW) | Outbound buffer word select |
| ctl_wbuf_data_o | output | 32 | Selected outbound buffer word |
| ctl_rbuf_we_i | input | 1 | Inbound buffer write strobe |
| ctl_rbuf_idx_i | input | clog2(NW) | Inbound buffer word select |
| ctl_rbuf_data_i | input | 32 | Inbound buffer write data |
| ctl_done_i | input | 1 | Completion strobe |
| ctl_err_i | input | 1 | Error flag, valid with done |
| ctl_err_code_i | input | 8 | Error code, valid with done |

## Verification
Two things can land in the same cycle: the host ringing the doorbell and the controller posting done for the previous command. The bench drives both strobes on one edge while busy is set. The expected result is the completion data latched, busy low afterwards, no interrupt pulse and the old command word kept, so the host has to ring again. Random traffic also mixes pointer, buffer, status and spurious-done accesses. Each result is compared against a register model kept in the bench.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
  localparam int unsigned DW = 32;
  localparam logic [31:0] OFF_CMD  = 32'h00;
  localparam logic [31:0] OFF_STAT = 32'h04;
  localparam logic [31:0] OFF_SPTR = 32'h08;
  localparam logic [31:0] OFF_DPTR = 32'h0C;
  localparam logic [31:0] WB_BASE  = 32'h80;

  typedef struct packed {
    logic [7:0] rsvd_hi;
    logic [7:0] code;
    logic [7:0] init_id;
    logic [3:0] cmd_id;
    logic [1:0] rsvd_lo;
    logic       err;
    logic       busy;
  } stat_t;
endpackage

// File: rtl/ipc_mbox_bank.sv
module ipc_mbox_bank #(
  parameter int unsigned NW = 4,
  parameter int unsigned DW = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [$clog2(NW)-1:0]     widx_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [NW-1:0][DW-1:0]     words_o
);
  for (genvar i = 0; i < NW; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   words_o[i] <= '0;
      else if (we_i && widx_i == ($clog2(NW))'(i))  words_o[i] <= wdata_i;
    end
  end

  AST_BANK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> words_o[$past(widx_i)] == $past(wdata_i)); // R8
endmodule

// File: rtl/ipc_mbox_seq.sv
module ipc_mbox_seq
  import ipc_mbox_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_wr_i,
  input  logic [31:0] cmd_i,
  input  logic [7:0]  id_i,
  input  logic        done_i,
  input  logic        err_i,
  input  logic [7:0]  code_i,
  output logic        irq_o,
  output logic [31:0] cmd_o,
  output stat_t       stat_o
);
  logic       busy_q, err_q, irq_q;
  logic [7:0] code_q, init_q;
  logic [31:0] cmd_q;
  logic accept, finish;

  assign accept = cmd_wr_i & ~busy_q;
  assign finish = done_i & busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      code_q <= '0;
      init_q <= '0;
      cmd_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= accept;
      if (accept) begin
        busy_q <= 1'b1;
        cmd_q  <= cmd_i;
        init_q <= id_i;
        err_q  <= 1'b0;
        code_q <= '0;
      end else if (finish) begin
        busy_q <= 1'b0;
        err_q  <= err_i;
        code_q <= code_i;
      end
    end
  end

  assign irq_o = irq_q;
  assign cmd_o = cmd_q;
  always_comb begin
    stat_o         = '0;
    stat_o.busy    = busy_q;
    stat_o.err     = err_q;
    stat_o.cmd_id  = cmd_q[15:12];
    stat_o.init_id = init_q;
    stat_o.code    = code_q;
  end

  AST_BUSY_ON_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !busy_q) |=> busy_q && irq_o); // R1
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R2
  AST_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && busy_q) |=> !irq_o && $stable(cmd_q)); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && busy_q) |=> !busy_q && err_q == $past(err_i) && code_q == $past(code_i)); // R4
  AST_IDLE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !busy_q && !cmd_wr_i) |=> $stable(stat_o)); // R5
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !busy_q) |=> !err_q && code_q == 8'h00); // R12
endmodule

// File: rtl/ipc_mbox.sv
module ipc_mbox
  import ipc_mbox_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned NW = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  host_wr_i,
  input  logic [AW-1:0]         host_addr_i,
  input  logic [31:0]           host_wdata_i,
  input  logic [3:0]            host_be_i,
  input  logic [7:0]            host_id_i,
  output logic [31:0]           host_rdata_o,
  output logic                  ctl_irq_o,
  output logic [31:0]           ctl_cmd_o,
  output logic [31:0]           ctl_sptr_o,
  output logic [31:0]           ctl_dptr_o,
  input  logic [$clog2(NW)-1:0] ctl_wbuf_idx_i,
  output logic [31:0]           ctl_wbuf_data_o,
  input  logic                  ctl_rbuf_we_i,
  input  logic [$clog2(NW)-1:0] ctl_rbuf_idx_i,
  input  logic [31:0]           ctl_rbuf_data_i,
  input  logic                  ctl_done_i,
  input  logic                  ctl_err_i,
  input  logic [7:0]            ctl_err_code_i
);
  localparam int unsigned IW = $clog2(NW);
  localparam logic [31:0] RB_BASE = WB_BASE + 32'(4 * NW);
  localparam logic [31:0] RB_END  = RB_BASE + 32'(4 * NW);

  logic [31:0] addr;
  logic        full_be, aligned;
  logic        hit_cmd, hit_stat, hit_sptr, hit_dptr, hit_wb, hit_rb;
  logic [IW-1:0] host_wb_idx, host_rb_idx;
  logic [31:0] sptr_q, dptr_q;
  logic [NW-1:0][DW-1:0] wb_words, rb_words;
  stat_t       stat;

  assign addr     = 32'(host_addr_i);
  assign full_be  = &host_be_i;
  assign aligned  = addr[1:0] == 2'b00;
  assign hit_cmd  = addr == OFF_CMD;
  assign hit_stat = addr == OFF_STAT;
  assign hit_sptr = addr == OFF_SPTR;
  assign hit_dptr = addr == OFF_DPTR;
  assign hit_wb   = aligned && addr >= WB_BASE && addr < RB_BASE;
  assign hit_rb   = aligned && addr >= RB_BASE && addr < RB_END;
  assign host_wb_idx = IW'((addr - WB_BASE) >> 2);
  assign host_rb_idx = IW'((addr - RB_BASE) >> 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sptr_q <= '0;
      dptr_q <= '0;
    end else if (host_wr_i && full_be) begin
      if (hit_sptr) sptr_q <= host_wdata_i;
      if (hit_dptr) dptr_q <= host_wdata_i;
    end
  end

  ipc_mbox_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_wr_i (host_wr_i && hit_cmd),
    .cmd_i    (host_wdata_i),
    .id_i     (host_id_i),
    .done_i   (ctl_done_i),
    .err_i    (ctl_err_i),
    .code_i   (ctl_err_code_i),
    .irq_o    (ctl_irq_o),
    .cmd_o    (ctl_cmd_o),
    .stat_o   (stat)
  );

  ipc_mbox_bank #(.NW(NW), .DW(DW)) u_wbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (host_wr_i && hit_wb && full_be),
    .widx_i  (host_wb_idx),
    .wdata_i (host_wdata_i),
    .words_o (wb_words)
  );

  ipc_mbox_bank #(.NW(NW), .DW(DW)) u_rbuf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_rbuf_we_i),
    .widx_i  (ctl_rbuf_idx_i),
    .wdata_i (ctl_rbuf_data_i),
    .words_o (rb_words)
  );

  assign ctl_wbuf_data_o = wb_words[ctl_wbuf_idx_i];
  assign ctl_sptr_o      = sptr_q;
  assign ctl_dptr_o      = dptr_q;

  always_comb begin
    host_rdata_o = '0;
    if (hit_stat)      host_rdata_o = stat;
    else if (hit_sptr) host_rdata_o = sptr_q;
    else if (hit_dptr) host_rdata_o = dptr_q;
    else if (hit_wb)   host_rdata_o = wb_words[host_wb_idx];
    else if (hit_rb)   host_rdata_o = rb_words[host_rb_idx];
  end

  AST_PTR_PARTIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && !full_be) |=> $stable(sptr_q) && $stable(dptr_q)); // R10
  AST_WB_PARTIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && hit_wb && !full_be) |=> $stable(wb_words)); // R8
  AST_RB_HOST_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && !ctl_rbuf_we_i) |=> $stable(rb_words)); // R9
endmodule

// File: tb/sim_ipc_mbox.sv
module sim_ipc_mbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [3:0]  host_be = '0;
  logic [7:0]  host_id = '0;
  logic [31:0] host_rdata;
  logic        irq;
  logic [31:0] cmd_o, sptr_o, dptr_o, wb_data;
  logic [1:0]  wb_idx = '0, rb_idx = '0;
  logic        rb_we = 1'b0;
  logic [31:0] rb_data = '0;
  logic        done = 1'b0, err = 1'b0;
  logic [7:0]  code = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [31:0] m_wb [4];
  logic [31:0] m_rb [4];
  logic [31:0] m_sptr, m_dptr, m_cmd;
  logic        m_busy, m_err;
  logic [7:0]  m_code, m_init;

  always #4 clk = ~clk;

  ipc_mbox u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(host_wr), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_be_i(host_be), .host_id_i(host_id),
    .host_rdata_o(host_rdata), .ctl_irq_o(irq), .ctl_cmd_o(cmd_o),
    .ctl_sptr_o(sptr_o), .ctl_dptr_o(dptr_o), .ctl_wbuf_idx_i(wb_idx),
    .ctl_wbuf_data_o(wb_data), .ctl_rbuf_we_i(rb_we), .ctl_rbuf_idx_i(rb_idx),
    .ctl_rbuf_data_i(rb_data), .ctl_done_i(done), .ctl_err_i(err),
    .ctl_err_code_i(code)
  );

  function automatic logic [31:0] exp_stat();
    return {8'h00, m_code, m_init, m_cmd[15:12], 2'b00, m_err, m_busy};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic hread(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic hwrite(logic [7:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d; host_be = be;
    @(negedge clk);
    host_wr = 1'b0;
    if (be == 4'hF) begin
      if (a == 8'h08) m_sptr = d;
      if (a == 8'h0C) m_dptr = d;
      if (a >= 8'h80 && a < 8'h90 && a[1:0] == 2'b00) m_wb[a[3:2]] = d;
    end
  endtask

  // doorbell, optionally colliding with a done strobe
  task automatic ring(logic [31:0] d, logic [7:0] id, bit with_done, bit e, logic [7:0] c);
    bit acc;
    @(negedge clk);
    host_wr = 1'b1; host_addr = 8'h00; host_wdata = d; host_be = 4'($urandom);
    host_id = id; done = with_done; err = e; code = c;
    acc = !m_busy;
    @(negedge clk);
    host_wr = 1'b0; done = 1'b0;
    if (acc) begin
      m_busy = 1'b1; m_cmd = d; m_init = id; m_err = 1'b0; m_code = 8'h00;
    end else if (with_done) begin
      m_busy = 1'b0; m_err = e; m_code = c;
    end
    check(acc ? "R2 irq after accept" : "R3 no irq when busy", 32'(irq), 32'(acc));
    check(acc ? "R1 cmd latched" : "R3 cmd kept", cmd_o, m_cmd);
  endtask

  task automatic finish_cmd(bit e, logic [7:0] c);
    @(negedge clk);
    done = 1'b1; err = e; code = c;
    @(negedge clk);
    done = 1'b0;
    if (m_busy) begin
      m_busy = 1'b0; m_err = e; m_code = c;
    end
  endtask

  task automatic ctl_write(logic [1:0] i, logic [31:0] d);
    @(negedge clk);
    rb_we = 1'b1; rb_idx = i; rb_data = d;
    @(negedge clk);
    rb_we = 1'b0;
    m_rb[i] = d;
  endtask

  task automatic check_status(string req);
    logic [31:0] d;
    hread(8'h04, d);
    check(req, d, exp_stat());
    check("R2 irq idle", 32'(irq), 32'h0);
  endtask

  task automatic check_all();
    logic [31:0] d;
    check_status("R6 status");
    for (int i = 0; i < 4; i++) begin
      hread(8'h80 + 8'(4 * i), d);
      check("R8 wbuf host", d, m_wb[i]);
      hread(8'h90 + 8'(4 * i), d);
      check("R9 rbuf host", d, m_rb[i]);
      @(negedge clk);
      wb_idx = 2'(i);
      #1 check("R8 wbuf ctl", wb_data, m_wb[i]);
    end
    check("R10 sptr", sptr_o, m_sptr);
    check("R10 dptr", dptr_o, m_dptr);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++) begin m_wb[i] = '0; m_rb[i] = '0; end
    m_sptr = '0; m_dptr = '0; m_cmd = '0; m_busy = 0; m_err = 0; m_code = '0; m_init = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    check_status("R11 status after reset");
    check("R11 cmd after reset", cmd_o, 32'h0);
    check_all();

    // R1 R6 basic doorbell
    hwrite(8'h80, 32'hCAFE_0001, 4'hF);
    ring(32'h0003_5142, 8'hA5, 0, 0, 0);
    check_status("R1 R6 busy and fields");
    // R7 command reads zero, status write ignored
    hread(8'h00, d);
    check("R7 cmd reads zero", d, 32'h0);
    hwrite(8'h04, 32'hFFFF_FFFF, 4'hF);
    check_status("R7 status write ignored");
    hread(8'h40, d);
    check("R7 unmapped reads zero", d, 32'h0);
    // R3 second doorbell ignored
    ring(32'h0000_9077, 8'h11, 0, 0, 0);
    check_status("R3 status kept");
    // R4 completion with error
    ctl_write(2'd1, 32'h1234_5678);
    finish_cmd(1, 8'h5C);
    check_status("R4 error captured");
    // R5 spurious done
    finish_cmd(0, 8'h00);
    check_status("R5 idle done ignored");
    // R12 next doorbell clears error
    ring(32'h0000_2001, 8'h02, 0, 0, 0);
    check_status("R12 error cleared");
    // collision: doorbell and done together while busy
    ring(32'h0000_7088, 8'h33, 1, 1, 8'hE1);
    check_status("R3 R4 collision");
    // R8 R10 partial writes dropped, R9 host write to rbuf ignored
    hwrite(8'h84, 32'hDEAD_BEEF, 4'h7);
    hwrite(8'h08, 32'h0BAD_0BAD, 4'hE);
    hwrite(8'h0C, 32'h1000_0000, 4'hF);
    hwrite(8'h94, 32'hFFFF_0000, 4'hF);
    check_all();

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom % 7);
      case (op)
        0: hwrite(8'h80 + 8'(4 * ($urandom % 8)), $urandom,
                  ($urandom % 3 == 0) ? 4'($urandom) : 4'hF);
        1: hwrite(($urandom % 2) ? 8'h08 : 8'h0C, $urandom,
                  ($urandom % 3 == 0) ? 4'($urandom) : 4'hF);
        2: ring($urandom, 8'($urandom), bit'($urandom % 4 == 0), bit'($urandom), 8'($urandom));
        3: finish_cmd(bit'($urandom), 8'($urandom));
        4: ctl_write(2'($urandom), $urandom);
        5: check_status("R6 random status");
        default: check_all();
      endcase
    end
    check_all();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule